// File: doc/BRIEF.md
# Interrupt Redirection and Destination Resolver

This block turns edges on a set of interrupt input pins into delivery messages for a group of up to eight CPUs. Each pin has a redirection entry, supplied as a static input bus, that sets the vector, the delivery mode, the addressing mode, the polarity, the trigger mode, a mask and a destination byte. When a pin rises, the block reads that pin's entry. A masked entry is discarded. For any other entry the block builds a message and works out which CPUs it targets, expressed as a bitmask.

Physical addressing selects one CPU by its ID, or selects every CPU when the destination is the broadcast value. Logical addressing compares the destination byte with each CPU's logical destination byte. Lowest-priority delivery narrows a logical target set to a single CPU, chosen by a rotating counter. An external-controller delivery takes its vector from a separate input.

Messages leave on a valid/ready handshake. Pin edges that arrive while the output is stalled, or in the same cycle as one another, are queued per pin and issued in ascending pin order.

Top module: `irq_route_top`

## Requirements
- R1: Only a low-to-high change of a pin, as seen between two consecutive clock edges, creates an event. A pin held high creates no further events, and a falling pin creates no event.
- R2: An event whose entry has the mask bit (entry bit 14) set produces no message and no error.
- R3: When the entry delivery mode (bits 10:8) is 3'b111, the message vector is `ext_vec_i`. For every other mode it is the entry vector (bits 7:0).
- R4: The message carries the entry's destination (bits 22:15), delivery mode (bits 10:8), addressing mode (bit 11, 1 = logical), polarity (bit 12, shown on `msg_level_o`) and trigger mode (bit 13).
- R5: In physical mode, destination 8'hFF targets all CPUs. Any other value targets only the CPU whose index equals the destination.
- R6: In logical mode, CPU c is targeted when `cpu_ldr_i[8c+7:8c]` AND the destination is nonzero.
- R7: Lowest-priority delivery (mode 3'b001) in logical mode with a non-empty match set targets the matching CPU at position (counter mod set size), counted in ascending CPU index. The counter starts at 0 after reset and increments once per such event.
- R8: Lowest-priority delivery in physical mode sends no message. Instead it raises `err_o` for exactly one cycle.
- R9: An unmasked event that resolves to an empty target set sends no message and raises no error.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, the message stays unchanged. Events pending together are issued in ascending pin order, one per accepted slot.
- R11: After reset, `msg_valid_o` and `err_o` are low. An event on an idle output is presented (or flagged) right after the clock edge that samples the rising pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Interrupt input pins |
| entries_i | input | NUM_PINS*23 | Redirection entry per pin, pin p at bits 23p+22:23p |
| cpu_ldr_i | input | NUM_CPUS*8 | Logical destination byte per CPU |
| ext_vec_i | input | 8 | Vector from the external interrupt controller |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_valid_o | output | 1 | Message present |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Delivery mode |
| msg_logical_o | output | 1 | Addressing mode, 1 = logical |
| msg_level_o | output | 1 | Level (entry polarity) |
| msg_trigger_o | output | 1 | Trigger mode |
| msg_dest_o | output | 8 | Destination byte |
| msg_targets_o | output | NUM_CPUS | Target CPU bitmask |
| err_o | output | 1 | One-cycle pulse: lowest-priority delivery in physical mode |

## Verification
A rising pin is resolved in the same cycle it is sampled, so the message, or the error pulse, appears one rising edge after the bench raises the pin. The bench changes inputs on falling edges and reads outputs 1 ns after the next rising edge. With ready held high a message lasts exactly one cycle, so the cycle that follows must be idle. Queued events each take one further edge, so the bench checks each vector edge by edge in pin order. A stalled message is checked at every edge until ready returns, and the queued event is checked on the edge that accepts the stalled one.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWPRI = 3'b001;
  localparam logic [2:0] DM_EXTINT = 3'b111;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trigger;
    logic       polarity;
    logic       logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  typedef struct packed {
    logic [7:0] dest;
    logic [2:0] dmode;
    logic       logical;
    logic       level;
    logic       trigger;
    logic [7:0] vector;
  } msg_t;
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                take_i,
  output logic                grant_vld_o,
  output logic [IDX_W-1:0]    grant_idx_o
);
  logic [NUM_PINS-1:0] pin_q, pend_q, req, grant_oh;

  assign req = pend_q | (pin_i & ~pin_q);

  always_comb begin
    grant_idx_o = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) grant_idx_o = IDX_W'(i);
    end
  end

  assign grant_vld_o = take_i && (|req);

  always_comb begin
    grant_oh = '0;
    if (grant_vld_o) grant_oh[grant_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '0;
      pend_q <= '0;
    end else begin
      pin_q  <= pin_i;
      pend_q <= req & ~grant_oh;
    end
  end

  assert_grant_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> (int'(grant_idx_o) < NUM_PINS));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_hold
    // high level with nothing queued must not requeue
    assert_no_retrigger_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_q[p] && pin_i[p] && !pend_q[p]) |=> !pend_q[p]);
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CNT_W    = 8
) (
  input  entry_t                ent_i,
  input  logic [NUM_CPUS*8-1:0] ldr_i,
  input  logic [7:0]            ext_vec_i,
  input  logic [CNT_W-1:0]      lp_cnt_i,
  output msg_t                  msg_o,
  output logic [NUM_CPUS-1:0]   targets_o,
  output logic                  send_o,
  output logic                  err_o,
  output logic                  lp_adv_o
);
  logic [NUM_CPUS-1:0] match, pick;
  logic [CNT_W-1:0]    set_size, slot, seen;
  logic                lowpri;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_match
    assign match[c] = ent_i.logical ? (|(ldr_i[c*8 +: 8] & ent_i.dest))
                                    : (ent_i.dest == 8'hFF || ent_i.dest == 8'(c));
  end

  always_comb begin
    set_size = '0;
    for (int c = 0; c < NUM_CPUS; c++) set_size = set_size + CNT_W'(match[c]);
    slot = lp_cnt_i % ((set_size == '0) ? CNT_W'(1) : set_size);
    pick = '0;
    seen = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (match[c]) begin
        if (seen == slot) pick[c] = 1'b1;
        seen = seen + CNT_W'(1);
      end
    end
  end

  assign lowpri    = (ent_i.dmode == DM_LOWPRI);
  assign err_o     = !ent_i.mask && lowpri && !ent_i.logical;
  assign targets_o = (lowpri && ent_i.logical) ? pick : match;
  assign send_o    = !ent_i.mask && !err_o && (|targets_o);
  assign lp_adv_o  = !ent_i.mask && lowpri && ent_i.logical && (|match);

  always_comb begin
    msg_o.dest    = ent_i.dest;
    msg_o.dmode   = ent_i.dmode;
    msg_o.logical = ent_i.logical;
    msg_o.level   = ent_i.polarity;
    msg_o.trigger = ent_i.trigger;
    msg_o.vector  = (ent_i.dmode == DM_EXTINT) ? ext_vec_i : ent_i.vector;
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int NUM_CPUS = 8,
  parameter int CNT_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_i,
  input  logic [NUM_PINS*ENT_W-1:0] entries_i,
  input  logic [NUM_CPUS*8-1:0]     cpu_ldr_i,
  input  logic [7:0]                ext_vec_i,
  input  logic                      msg_ready_i,
  output logic                      msg_valid_o,
  output logic [7:0]                msg_vector_o,
  output logic [2:0]                msg_dmode_o,
  output logic                      msg_logical_o,
  output logic                      msg_level_o,
  output logic                      msg_trigger_o,
  output logic [7:0]                msg_dest_o,
  output logic [NUM_CPUS-1:0]       msg_targets_o,
  output logic                      err_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic                take, grant_vld, send, err, lp_adv;
  logic [IDX_W-1:0]    grant_idx;
  entry_t              ent;
  msg_t                msg, msg_q;
  logic [NUM_CPUS-1:0] targets, tgt_q;
  logic                vld_q, err_q;
  logic [CNT_W-1:0]    lp_cnt_q;

  assign take = !vld_q || msg_ready_i;

  irq_pin_tracker #(.NUM_PINS(NUM_PINS)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .take_i     (take),
    .grant_vld_o(grant_vld),
    .grant_idx_o(grant_idx)
  );

  assign ent = entry_t'(entries_i[int'(grant_idx)*ENT_W +: ENT_W]);

  irq_dest_resolver #(.NUM_CPUS(NUM_CPUS), .CNT_W(CNT_W)) u_resolve (
    .ent_i    (ent),
    .ldr_i    (cpu_ldr_i),
    .ext_vec_i(ext_vec_i),
    .lp_cnt_i (lp_cnt_q),
    .msg_o    (msg),
    .targets_o(targets),
    .send_o   (send),
    .err_o    (err),
    .lp_adv_o (lp_adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      msg_q    <= '0;
      tgt_q    <= '0;
      lp_cnt_q <= '0;
    end else begin
      err_q <= grant_vld && err;
      if (take) vld_q <= grant_vld && send;
      if (grant_vld && send) begin
        msg_q <= msg;
        tgt_q <= targets;
      end
      if (grant_vld && lp_adv) lp_cnt_q <= lp_cnt_q + CNT_W'(1);
    end
  end

  assign msg_valid_o   = vld_q;
  assign msg_vector_o  = msg_q.vector;
  assign msg_dmode_o   = msg_q.dmode;
  assign msg_logical_o = msg_q.logical;
  assign msg_level_o   = msg_q.level;
  assign msg_trigger_o = msg_q.trigger;
  assign msg_dest_o    = msg_q.dest;
  assign msg_targets_o = tgt_q;
  assign err_o         = err_q;

  assert_hold_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_q) && $stable(tgt_q)));

  assert_targets_nonempty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_targets_o != '0));

  assert_lowpri_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_dmode_o == DM_LOWPRI) |-> ($countones(msg_targets_o) == 1));

  assert_lowpri_logical_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_dmode_o == DM_LOWPRI) |-> msg_logical_o);

  assert_err_no_issue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(msg_valid_o)) |-> !msg_valid_o);
endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
  localparam int NP = 24;
  localparam int NC = 8;
  localparam int EW = irq_route_pkg::ENT_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [NP-1:0]     pin;
  logic [NP*EW-1:0]  entries;
  logic [NC*8-1:0]   ldr;
  logic [7:0]        ext_vec;
  logic              ready;
  logic              valid, level, trigger, logical, err;
  logic [7:0]        vector, dest;
  logic [2:0]        dmode;
  logic [NC-1:0]     targets;

  int checks = 0;
  int fails  = 0;

  irq_route_top #(.NUM_PINS(NP), .NUM_CPUS(NC), .CNT_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .entries_i(entries), .cpu_ldr_i(ldr),
    .ext_vec_i(ext_vec), .msg_ready_i(ready), .msg_valid_o(valid), .msg_vector_o(vector),
    .msg_dmode_o(dmode), .msg_logical_o(logical), .msg_level_o(level),
    .msg_trigger_o(trigger), .msg_dest_o(dest), .msg_targets_o(targets), .err_o(err)
  );

  function automatic logic [22:0] mk(input logic [7:0] d, input logic m, input logic tr,
                                     input logic pol, input logic lg, input logic [2:0] dm,
                                     input logic [7:0] v);
    return {d, m, tr, pol, lg, dm, v};
  endfunction

  task automatic set_ent(input int p, input logic [22:0] v);
    entries[p*EW +: EW] = v;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input int p);
    @(negedge clk); pin[p] = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic lower(input int p);
    @(negedge clk); pin[p] = 1'b0;
  endtask

  task automatic chk_msg(input string req, input logic [7:0] v, input logic [NC-1:0] t);
    chk({req, " valid"}, 32'(valid), 32'd1);
    chk({req, " vector"}, 32'(vector), 32'(v));
    chk({req, " targets"}, 32'(targets), 32'(t));
  endtask

  task automatic chk_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk({req, " idle valid"}, 32'(valid), 32'd0);
      chk({req, " idle err"}, 32'(err), 32'd0);
    end
  endtask

  task automatic t_reset();
    chk("R11 reset valid", 32'(valid), 32'd0);
    chk("R11 reset err", 32'(err), 32'd0);
  endtask

  task automatic t_fixed();
    set_ent(3, mk(8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 8'h41));
    fire(3);
    chk_msg("R11 R5 fixed", 8'h41, 8'h04);
    chk("R4 dest", 32'(dest), 32'h02);
    chk("R4 dmode", 32'(dmode), 32'h0);
    chk("R4 logical", 32'(logical), 32'h0);
    chk("R4 level", 32'(level), 32'h0);
    chk("R4 trigger", 32'(trigger), 32'h1);
    chk_idle("R1 held high", 4);
    lower(3);
    chk_idle("R1 falling", 3);
    fire(3);
    chk_msg("R1 re-rise", 8'h41, 8'h04);
    lower(3);
  endtask

  task automatic t_mask();
    set_ent(6, mk(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h66));
    fire(6);
    chk("R2 masked valid", 32'(valid), 32'd0);
    chk("R2 masked err", 32'(err), 32'd0);
    lower(6);
    chk_idle("R2 masked", 2);
  endtask

  task automatic t_extint();
    ext_vec = 8'h99;
    set_ent(8, mk(8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 8'h10));
    fire(8);
    chk_msg("R3 extint", 8'h99, 8'h02);
    chk("R4 extint dmode", 32'(dmode), 32'h7);
    chk("R4 extint level", 32'(level), 32'h1);
    chk("R4 extint trigger", 32'(trigger), 32'h0);
    lower(8);
  endtask

  task automatic t_physical();
    set_ent(9, mk(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h20));
    fire(9);
    chk_msg("R5 broadcast", 8'h20, 8'hFF);
    lower(9);
    set_ent(9, mk(8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'h21));
    fire(9);
    chk("R9 phys out of range valid", 32'(valid), 32'd0);
    chk("R9 phys out of range err", 32'(err), 32'd0);
    lower(9);
  endtask

  task automatic t_logical();
    set_ent(10, mk(8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h30));
    fire(10);
    chk_msg("R6 logical 01", 8'h30, 8'h13);
    chk("R4 logical flag", 32'(logical), 32'h1);
    lower(10);
    set_ent(10, mk(8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h31));
    fire(10);
    chk_msg("R6 logical 80", 8'h31, 8'h10);
    lower(10);
    set_ent(10, mk(8'h40, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 8'h32));
    fire(10);
    chk("R9 logical empty valid", 32'(valid), 32'd0);
    chk("R9 logical empty err", 32'(err), 32'd0);
    lower(10);
  endtask

  task automatic lp(input logic [7:0] d, input logic [NC-1:0] t, input string req);
    set_ent(11, mk(d, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 8'h50));
    fire(11);
    if (t == '0) begin
      chk({req, " valid"}, 32'(valid), 32'd0);
      chk({req, " err"}, 32'(err), 32'd0);
    end else begin
      chk_msg(req, 8'h50, t);
    end
    lower(11);
  endtask

  task automatic t_lowpri();
    lp(8'h01, 8'h01, "R7 rot0");
    lp(8'h01, 8'h02, "R7 rot1");
    lp(8'h01, 8'h10, "R7 rot2");
    lp(8'h01, 8'h01, "R7 wrap");
    lp(8'h04, 8'h04, "R7 single");
    lp(8'h03, 8'h10, "R7 cnt5 mod3");
    lp(8'h40, 8'h00, "R9 lowpri empty");
    lp(8'h01, 8'h01, "R7 no advance on empty");
  endtask

  task automatic t_lowpri_phys();
    set_ent(12, mk(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 8'h70));
    fire(12);
    chk("R8 err raised", 32'(err), 32'd1);
    chk("R8 no message", 32'(valid), 32'd0);
    @(posedge clk); #1;
    chk("R8 err one cycle", 32'(err), 32'd0);
    lower(12);
  endtask

  task automatic t_order();
    set_ent(13, mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'hD3));
    set_ent(15, mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'hD5));
    set_ent(20, mk(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'hD4));
    @(negedge clk);
    pin[15] = 1'b1; pin[13] = 1'b1; pin[20] = 1'b1;
    @(posedge clk); #1;
    chk_msg("R10 order first", 8'hD3, 8'h01);
    @(posedge clk); #1;
    chk_msg("R10 order second", 8'hD5, 8'h01);
    @(posedge clk); #1;
    chk_msg("R10 order third", 8'hD4, 8'h01);
    chk_idle("R10 order drained", 1);
    @(negedge clk);
    pin[15] = 1'b0; pin[13] = 1'b0; pin[20] = 1'b0;
  endtask

  task automatic t_stall();
    set_ent(16, mk(8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'hE0));
    set_ent(14, mk(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 8'hE1));
    @(negedge clk); ready = 1'b0;
    fire(16);
    chk_msg("R10 stall first", 8'hE0, 8'h08);
    @(negedge clk); pin[14] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk_msg("R10 stall hold", 8'hE0, 8'h08);
    end
    @(negedge clk); ready = 1'b1;
    @(posedge clk); #1;
    chk_msg("R10 queued after stall", 8'hE1, 8'h02);
    chk_idle("R10 stall drained", 1);
    @(negedge clk); pin[14] = 1'b0; pin[16] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    pin     = '0;
    entries = '0;
    ext_vec = 8'h00;
    ready   = 1'b1;
    ldr     = '0;
    ldr[0*8 +: 8] = 8'h01;
    ldr[1*8 +: 8] = 8'h03;
    ldr[2*8 +: 8] = 8'h04;
    ldr[3*8 +: 8] = 8'h00;
    ldr[4*8 +: 8] = 8'h81;
    for (int p = 0; p < NP; p++) set_ent(p, mk(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 8'h00));
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_fixed();
    t_mask();
    t_extint();
    t_physical();
    t_logical();
    t_lowpri();
    t_lowpri_phys();
    t_order();
    t_stall();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule